// File: doc/BRIEF.md
# Coherent Target Command Classifier

This block sits on the request side of a shared memory controller. Processors send request packets over a valid/ready command channel. For each packet the block checks which address window the first flit falls in: the memory window or the configuration window. It then works out the request kind from the two-bit command code and the low bits of the packet id. Every flit of the packet goes to the one downstream queue chosen for it. The possible queues are read, write, linked-load, store-conditional, compare-and-swap and configuration. A flit is handed over by a one-cycle push strobe, and the queue takes the payload straight from the command bus.

The block does not stop when it sees an illegal packet. It accepts every flit of that packet up to the end-of-packet flit and pushes none of them. One cycle after the end-of-packet flit it raises an error-response request, which carries the source, transaction and packet ids of the packet's first flit. For configuration accesses it splits the word address into a function index and a register index. A full destination queue holds off the channel by dropping ready. No flit is lost.

Top module: `coh_cmd_router`

## Requirements
- R1: A first flit whose address falls in neither the memory window (default 0x0000_0000 to 0x000F_FFFF) nor the configuration window (default 0xF000_0000 to 0xF000_0FFF) marks its packet as illegal.
- R2: A memory read (code 1) is legal only when packet-id bit 2 is 0 and the packet is a single flit. It pulses `rd_push`. `rd_line` is 1 when the length field equals the line size (64 bytes) and 0 for any other length.
- R3: A memory write (code 2) is legal only when the low three packet-id bits are 000 or 100. Each of its flits pulses `wr_push`.
- R4: A memory linked-load (code 3) is legal only when the low three packet-id bits are 110 and the packet is a single flit. It pulses `ll_push`.
- R5: A memory no-op-class request (code 0) with low packet-id bits 101 is a compare-and-swap: each of its flits pulses `cas_push`. With 111 it is a store-conditional and pulses `sc_push`. Any other value is illegal.
- R6: A configuration request must be a single-flit read or write. It pulses `cfg_push`, with `cfg_reg` taken from address bits [6:2] and `cfg_func` from address bits [10:7].
- R7: A configuration write to register index 0 (the buffer address) is illegal unless its data is a multiple of the 64-byte line size.
- R8: The flits of an illegal packet are accepted without any push. One cycle after its end-of-packet flit is accepted, `err_req` is high for one cycle. It carries the first flit's source id, transaction id and packet id.
- R9: When the queue chosen for the current flit is full, `cmd_ready` is 0 and no push occurs. Flits bound for queues that are not full are not held up.
- R10: After reset, and whenever no flit is offered, no push strobe and no error request is active. At most one push strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command flit offered |
| cmd_ready | output | 1 | Command flit accepted this cycle |
| cmd_addr | input | AW | Byte address |
| cmd_code | input | 2 | 0 no-op class, 1 read, 2 write, 3 linked-load |
| cmd_srcid | input | SW | Source id |
| cmd_trdid | input | TW | Transaction id |
| cmd_pktid | input | PW | Packet id (type bits) |
| cmd_plen | input | LW | Packet length in bytes |
| cmd_wdata | input | DW | Flit data |
| cmd_eop | input | 1 | Last flit of packet |
| rd_full | input | 1 | Read queue full |
| wr_full | input | 1 | Write queue full |
| ll_full | input | 1 | Linked-load queue full |
| sc_full | input | 1 | Store-conditional queue full |
| cas_full | input | 1 | Compare-and-swap queue full |
| cfg_full | input | 1 | Configuration queue full |
| rd_push | output | 1 | Push into read queue |
| rd_line | output | 1 | Read targets a whole line |
| wr_push | output | 1 | Push into write queue |
| ll_push | output | 1 | Push into linked-load queue |
| sc_push | output | 1 | Push into store-conditional queue |
| cas_push | output | 1 | Push into compare-and-swap queue |
| cfg_push | output | 1 | Push into configuration queue |
| cfg_func | output | FUNC_BITS | Configuration function index |
| cfg_reg | output | REG_BITS | Configuration register index |
| err_req | output | 1 | Error-response request |
| err_srcid | output | SW | Error response source id |
| err_trdid | output | TW | Error response transaction id |
| err_pktid | output | PW | Error response packet id |

## Verification
The push strobes, `rd_line`, the configuration indices and `cmd_ready` are combinational. They are due in the same cycle as the flit that causes them. The error request and its ids are registered and are due exactly one cycle after the end-of-packet flit is accepted. The bench's reference model follows this split. It works out the same-cycle outputs from the inputs now on the bus, and it produces the error request from a value it stored at the previous edge. Inputs change just after a rising edge, and every output is compared at the falling edge, when both the design and the model have settled.

// File: rtl/coh_cmd_router.sv
module coh_cmd_router #(
  parameter int AW = 32,
  parameter int SW = 8,
  parameter int TW = 4,
  parameter int PW = 4,
  parameter int LW = 8,
  parameter int DW = 32,
  parameter int MEM_BITS = 20,
  parameter int CFG_BITS = 12,
  parameter logic [AW-1:0] MEM_BASE = '0,
  parameter logic [AW-1:0] CFG_BASE = AW'(32'hF000_0000),
  parameter int WORD_BYTES = 4,
  parameter int REG_BITS = 5,
  parameter int FUNC_BITS = 4,
  parameter int LINE_BYTES = 64,
  parameter int BUF_REG = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [AW-1:0]  cmd_addr,
  input  logic [1:0]     cmd_code,
  input  logic [SW-1:0]  cmd_srcid,
  input  logic [TW-1:0]  cmd_trdid,
  input  logic [PW-1:0]  cmd_pktid,
  input  logic [LW-1:0]  cmd_plen,
  input  logic [DW-1:0]  cmd_wdata,
  input  logic           cmd_eop,
  input  logic           rd_full,
  input  logic           wr_full,
  input  logic           ll_full,
  input  logic           sc_full,
  input  logic           cas_full,
  input  logic           cfg_full,
  output logic           rd_push,
  output logic           rd_line,
  output logic           wr_push,
  output logic           ll_push,
  output logic           sc_push,
  output logic           cas_push,
  output logic           cfg_push,
  output logic [FUNC_BITS-1:0] cfg_func,
  output logic [REG_BITS-1:0]  cfg_reg,
  output logic           err_req,
  output logic [SW-1:0]  err_srcid,
  output logic [TW-1:0]  err_trdid,
  output logic [PW-1:0]  err_pktid
);
  localparam int WB_SH   = $clog2(WORD_BYTES);
  localparam int LINE_SH = $clog2(LINE_BYTES);
  localparam logic [1:0] C_NOP = 2'd0, C_RD = 2'd1, C_WR = 2'd2, C_LL = 2'd3;

  typedef enum logic [2:0] {D_RD, D_WR, D_LL, D_SC, D_CAS, D_CFG, D_ERR} dest_t;

  logic  busy;
  dest_t cur_dest, first_dest, dest;
  logic  mem_hit, cfg_hit, buf_bad, dest_full, fire;
  logic [2:0] ty;
  logic unused_bits;

  assign mem_hit  = cmd_addr[AW-1:MEM_BITS] == MEM_BASE[AW-1:MEM_BITS];
  assign cfg_hit  = cmd_addr[AW-1:CFG_BITS] == CFG_BASE[AW-1:CFG_BITS];
  assign ty       = cmd_pktid[2:0];
  assign cfg_reg  = cmd_addr[WB_SH +: REG_BITS];
  assign cfg_func = cmd_addr[WB_SH+REG_BITS +: FUNC_BITS];
  assign buf_bad  = (cmd_code == C_WR) && (cfg_reg == REG_BITS'(BUF_REG))
                    && (|cmd_wdata[LINE_SH-1:0]);
  assign rd_line  = cmd_plen == LW'(LINE_BYTES);
  assign unused_bits = ^{cmd_addr, cmd_wdata, cmd_pktid};

  always_comb begin
    first_dest = D_ERR;
    if (mem_hit) begin
      case (cmd_code)
        C_RD:    if (!ty[2] && cmd_eop) first_dest = D_RD;
        C_WR:    if (ty == 3'b000 || ty == 3'b100) first_dest = D_WR;
        C_LL:    if (ty == 3'b110 && cmd_eop) first_dest = D_LL;
        default: if (ty == 3'b101) first_dest = D_CAS;
                 else if (ty == 3'b111) first_dest = D_SC;
      endcase
    end else if (cfg_hit) begin
      if (cmd_eop && (cmd_code == C_RD || cmd_code == C_WR) && !buf_bad)
        first_dest = D_CFG;
    end
  end

  assign dest = busy ? cur_dest : first_dest;

  always_comb begin
    case (dest)
      D_RD:    dest_full = rd_full;
      D_WR:    dest_full = wr_full;
      D_LL:    dest_full = ll_full;
      D_SC:    dest_full = sc_full;
      D_CAS:   dest_full = cas_full;
      D_CFG:   dest_full = cfg_full;
      default: dest_full = 1'b0;
    endcase
  end

  assign cmd_ready = !dest_full;
  assign fire      = cmd_valid && cmd_ready;
  assign rd_push   = fire && dest == D_RD;
  assign wr_push   = fire && dest == D_WR;
  assign ll_push   = fire && dest == D_LL;
  assign sc_push   = fire && dest == D_SC;
  assign cas_push  = fire && dest == D_CAS;
  assign cfg_push  = fire && dest == D_CFG;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cur_dest  <= D_ERR;
      err_req   <= 1'b0;
      err_srcid <= '0;
      err_trdid <= '0;
      err_pktid <= '0;
    end else begin
      err_req <= fire && cmd_eop && dest == D_ERR;
      if (fire) begin
        busy     <= !cmd_eop;
        cur_dest <= dest;
        if (!busy) begin
          err_srcid <= cmd_srcid;
          err_trdid <= cmd_trdid;
          err_pktid <= cmd_pktid;
        end
      end
    end
  end
endmodule

// File: rtl/coh_cmd_router_chk.sv
module coh_cmd_router_chk #(
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_eop,
  input logic [PW-1:0] cmd_pktid,
  input logic          rd_full,
  input logic          wr_full,
  input logic          ll_full,
  input logic          sc_full,
  input logic          cas_full,
  input logic          cfg_full,
  input logic          rd_push,
  input logic          wr_push,
  input logic          ll_push,
  input logic          sc_push,
  input logic          cas_push,
  input logic          cfg_push,
  input logic          err_req
);
  a_r2_read_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_push |-> (cmd_eop && !cmd_pktid[2]));

  a_r4_ll_single: assert property (@(posedge clk) disable iff (!rst_n)
    ll_push |-> (cmd_eop && cmd_pktid[2:0] == 3'b110));

  a_r6_cfg_single: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_push |-> cmd_eop);

  a_r8_err_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    err_req |-> $past(cmd_valid && cmd_ready && cmd_eop));

  a_r9_no_push_into_full: assert property (@(posedge clk) disable iff (!rst_n)
    !((rd_push && rd_full) || (wr_push && wr_full) || (ll_push && ll_full) ||
      (sc_push && sc_full) || (cas_push && cas_full) || (cfg_push && cfg_full)));

  a_r10_one_push: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_push, wr_push, ll_push, sc_push, cas_push, cfg_push}));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> !(rd_push || wr_push || ll_push || sc_push || cas_push || cfg_push));
endmodule

bind coh_cmd_router coh_cmd_router_chk #(.PW(PW)) u_chk (.*);

// File: tb/coh_cmd_router_test.sv
`timescale 1ns/1ps
module coh_cmd_router_test;
  localparam int DRD = 1, DWR = 2, DLL = 3, DSC = 4, DCAS = 5, DCFG = 6, DERR = 7;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_eop = 0;
  logic [31:0] cmd_addr = 0, cmd_wdata = 0;
  logic [1:0]  cmd_code = 0;
  logic [7:0]  cmd_srcid = 0, cmd_plen = 0;
  logic [3:0]  cmd_trdid = 0, cmd_pktid = 0;
  logic rd_full = 0, wr_full = 0, ll_full = 0, sc_full = 0, cas_full = 0, cfg_full = 0;
  logic cmd_ready, rd_push, rd_line, wr_push, ll_push, sc_push, cas_push, cfg_push, err_req;
  logic [3:0] cfg_func;
  logic [4:0] cfg_reg;
  logic [7:0] err_srcid;
  logic [3:0] err_trdid, err_pktid;

  int n_checks = 0, n_errors = 0, err_seen = 0;
  int m_busy = 0, m_dest = 0, m_src = 0, m_trd = 0, m_pkt = 0, m_err = 0;

  always #4 clk = ~clk;

  coh_cmd_router uut (.*);

  task automatic check(input bit ok, input string tag, input string what, input int got, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic int mdl_dest();
    int p, rg;
    if (m_busy != 0) return m_dest;
    p = int'(cmd_pktid) % 8;
    if (cmd_addr < 32'h0010_0000) begin
      if (cmd_code == 1) return (p < 4 && cmd_eop) ? DRD : DERR;
      if (cmd_code == 2) return (p == 0 || p == 4) ? DWR : DERR;
      if (cmd_code == 3) return (p == 6 && cmd_eop) ? DLL : DERR;
      return (p == 5) ? DCAS : ((p == 7) ? DSC : DERR);
    end
    if (cmd_addr >= 32'hF000_0000 && cmd_addr < 32'hF000_1000) begin
      rg = int'(cmd_addr >> 2) % 32;
      if (!cmd_eop || !(cmd_code == 1 || cmd_code == 2)) return DERR;
      if (cmd_code == 2 && rg == 0 && (cmd_wdata % 64) != 0) return DERR;
      return DCFG;
    end
    return DERR;
  endfunction

  function automatic bit mdl_full(input int d);
    case (d)
      DRD: return rd_full;   DWR: return wr_full;   DLL: return ll_full;
      DSC: return sc_full;   DCAS: return cas_full; DCFG: return cfg_full;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_dest = 0; m_err = 0; m_src = 0; m_trd = 0; m_pkt = 0;
    end else begin
      int d; bit f;
      d = mdl_dest();
      f = cmd_valid && !mdl_full(d);
      m_err = (f && cmd_eop && d == DERR) ? 1 : 0;
      if (f) begin
        if (m_busy == 0) begin m_src = cmd_srcid; m_trd = cmd_trdid; m_pkt = cmd_pktid; end
        m_busy = cmd_eop ? 0 : 1;
        m_dest = d;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    int d; bit rdy, f;
    d = mdl_dest();
    rdy = !mdl_full(d);
    f = cmd_valid && rdy;
    check(cmd_ready == rdy, "R9", "cmd_ready", cmd_ready, rdy);
    check(rd_push == (f && d == DRD), "R2", "rd_push", rd_push, f && d == DRD);
    check(wr_push == (f && d == DWR), "R3", "wr_push", wr_push, f && d == DWR);
    check(ll_push == (f && d == DLL), "R4", "ll_push", ll_push, f && d == DLL);
    check(sc_push == (f && d == DSC), "R5", "sc_push", sc_push, f && d == DSC);
    check(cas_push == (f && d == DCAS), "R5", "cas_push", cas_push, f && d == DCAS);
    check(cfg_push == (f && d == DCFG), "R6", "cfg_push", cfg_push, f && d == DCFG);
    if (rd_push) check(rd_line == (cmd_plen == 64), "R2", "rd_line", rd_line, cmd_plen == 64);
    if (cfg_push) begin
      check(cfg_reg == (cmd_addr >> 2) % 32, "R6", "cfg_reg", cfg_reg, (cmd_addr >> 2) % 32);
      check(cfg_func == (cmd_addr >> 7) % 16, "R6", "cfg_func", cfg_func, (cmd_addr >> 7) % 16);
    end
    check(err_req == m_err, "R8", "err_req", err_req, m_err);
    if (m_err != 0) begin
      check(err_srcid == m_src, "R8", "err_srcid", err_srcid, m_src);
      check(err_trdid == m_trd, "R8", "err_trdid", err_trdid, m_trd);
      check(err_pktid == m_pkt, "R8", "err_pktid", err_pktid, m_pkt);
    end
    if (err_req) err_seen++;
  end

  task automatic send(input logic [31:0] a, input logic [1:0] c, input logic [3:0] p,
                      input int nfl, input logic [7:0] len, input logic [31:0] d);
    for (int i = 0; i < nfl; i++) begin
      bit ok;
      cmd_valid = 1; cmd_addr = a; cmd_code = c; cmd_pktid = p; cmd_plen = len;
      cmd_wdata = d + i; cmd_eop = (i == nfl - 1);
      cmd_srcid = 8'h30 + 8'(a[7:0]); cmd_trdid = 4'(p + 4'd3);
      forever begin
        @(negedge clk); ok = cmd_ready;
        @(posedge clk); #1;
        if (ok) break;
      end
    end
    cmd_valid = 0; cmd_eop = 0;
    @(posedge clk); #1;
  endtask

  task automatic expect_err(input int base, input int n, input string tag);
    check(err_seen - base == n, tag, "error responses", err_seen - base, n);
  endtask

  initial begin
    #(8 * 200000);
    n_errors++;
    $display("FAIL R8 watchdog expired: actual 0 expected 1");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int b;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    check(!(rd_push || wr_push || ll_push || sc_push || cas_push || cfg_push), "R10", "pushes after reset", 1, 0);
    check(err_req == 0, "R10", "err_req after reset", err_req, 0);
    @(posedge clk); #1;

    b = err_seen;
    send(32'h0000_0100, 2'd1, 4'h0, 1, 8'd4, 0);
    send(32'h0000_0140, 2'd1, 4'h1, 1, 8'd64, 0);
    expect_err(b, 0, "R2");
    b = err_seen;
    send(32'h0000_0180, 2'd1, 4'h4, 1, 8'd4, 0);
    send(32'h0000_01C0, 2'd1, 4'h0, 2, 8'd8, 0);
    expect_err(b, 2, "R2");

    b = err_seen;
    send(32'h0000_0200, 2'd2, 4'h0, 3, 8'd12, 32'h10);
    send(32'h0000_0204, 2'd2, 4'hC, 2, 8'd8, 32'h20);
    expect_err(b, 0, "R3");
    b = err_seen;
    send(32'h0000_0208, 2'd2, 4'h2, 2, 8'd8, 32'h30);
    expect_err(b, 1, "R3");

    b = err_seen;
    send(32'h0000_0300, 2'd3, 4'h6, 1, 8'd4, 0);
    send(32'h0000_0304, 2'd3, 4'h6, 2, 8'd8, 0);
    send(32'h0000_0308, 2'd3, 4'h2, 1, 8'd4, 0);
    expect_err(b, 2, "R4");

    b = err_seen;
    send(32'h0000_0400, 2'd0, 4'hD, 2, 8'd8, 32'h55);
    send(32'h0000_0404, 2'd0, 4'h7, 1, 8'd4, 32'h66);
    send(32'h0000_0408, 2'd0, 4'h1, 1, 8'd4, 0);
    expect_err(b, 1, "R5");

    b = err_seen;
    send(32'hF000_0000 | (3 << 7) | (9 << 2), 2'd1, 4'h0, 1, 8'd4, 0);
    send(32'hF000_0000 | (15 << 7) | (31 << 2), 2'd2, 4'h0, 1, 8'd4, 32'h7);
    send(32'hF000_0010, 2'd2, 4'h0, 2, 8'd8, 0);
    send(32'hF000_0014, 2'd3, 4'h6, 1, 8'd4, 0);
    expect_err(b, 2, "R6");

    b = err_seen;
    send(32'hF000_0000 | (2 << 7), 2'd2, 4'h0, 1, 8'd4, 32'h0000_0040);
    send(32'hF000_0000 | (2 << 7), 2'd2, 4'h0, 1, 8'd4, 32'h0000_0044);
    send(32'hF000_0004, 2'd2, 4'h0, 1, 8'd4, 32'h0000_0044);
    expect_err(b, 1, "R7");

    b = err_seen;
    send(32'h8000_0000, 2'd1, 4'h0, 1, 8'd4, 0);
    send(32'hF000_1000, 2'd1, 4'h0, 1, 8'd4, 0);
    send(32'h0010_0000, 2'd2, 4'h0, 3, 8'd12, 0);
    expect_err(b, 3, "R1");

    b = err_seen;
    wr_full = 1;
    send(32'h0000_0500, 2'd1, 4'h0, 1, 8'd4, 0);
    fork
      send(32'h0000_0504, 2'd2, 4'h4, 2, 8'd8, 32'h99);
      begin repeat (4) @(posedge clk); #2; wr_full = 0; end
    join
    cas_full = 1;
    fork
      send(32'h0000_0508, 2'd0, 4'h5, 2, 8'd8, 32'hA0);
      begin repeat (2) @(posedge clk); #2; cas_full = 0; end
    join
    expect_err(b, 0, "R9");

    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule